// File: doc/BRIEF.md
# Cache Test-Register Flush Controller

This block holds the per-line coherence state and the per-set pseudo-LRU bits of a four-way set-associative write-back cache, and gives test software a register path into them. An entry register selects one set and one way. A control register carries a two-bit command: read the selected entry into a status register, write the selected entry's state bits, write the selected set's LRU bits, or flush. The tag and data arrays are not part of this block.

The flush command has two forms, chosen by a line-select bit in the control register. With the bit clear, every line and every LRU field is cleared in a single clock and nothing is written back. With the bit set, only the addressed line is touched: a Modified line is first handed to the data path through a request/acknowledge handshake and then invalidated, while a line in any other state is invalidated at once. A test-register flush never produces an external flush announcement; the block has no such output. A mode input selects write-back operation or write-through compatibility, where only Shared and Invalid are legal and the high state bit acts as the valid bit.

Top module: `cache_tr_flush`

## Requirements
- R1: After reset every line is Invalid (state 2'b00), every LRU field is 0, `busy` and `wb_req` are low, and the status register reads 0.
- R2: Line state is two bits {H,L} with Modified = 2'b11, Exclusive = 2'b01, Shared = 2'b10, Invalid = 2'b00. Control command 2'b01 (bits 1:0) writes bits 3:2 into the selected entry; command 2'b00 loads the status register at the next clock edge, and in write-back mode (`wb_mode` = 1) the status holds the selected entry's state in bits 1:0 with bits 3:2 zero.
- R3: In write-through mode (`wb_mode` = 0) a state write stores only the H bit (L forced to 0), and the status holds the H bit of way n in bit n for n = 0..3.
- R4: Command 2'b10 writes control bits 6:4 into the selected set's LRU field; the status always shows that set's LRU field in bits 6:4.
- R5: Command 2'b11 with bit 13 = 0 makes every line Invalid and every LRU field 0 at the next clock edge, with `busy` and `wb_req` staying low.
- R6: Command 2'b11 with bit 13 = 1 on a line that is not Modified makes that line Invalid at the next clock edge, without `busy` or `wb_req`, leaving other lines and the LRU bits unchanged.
- R7: Command 2'b11 with bit 13 = 1 on a Modified line raises `busy` and `wb_req` at the next edge, with `wb_set`/`wb_way` naming the line, which stays Modified until acknowledged.
- R8: `wb_req`, `wb_set` and `wb_way` hold until `wb_ack`; the edge on which `wb_ack` is seen makes the line Invalid and drops `wb_req` and `busy`.
- R9: Control and entry register writes made while `busy` is high are ignored.
- R10: With command 2'b11, every control bit other than 1:0 and 13 is ignored.
- R11: The entry register takes the way from bits 1:0 and the set from bits SET_W+1:2 of `ent_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode | input | 1 | 1 = write-back operation, 0 = write-through compatibility |
| ent_we | input | 1 | Entry register write strobe |
| ent_wdata | input | SET_W+2 | Set index and way select |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 14 | Command, line-select bit and operands |
| stat_rdata | output | 32 | Status register |
| busy | output | 1 | Line write-back in progress |
| wb_req | output | 1 | Write-back request to the data path |
| wb_set | output | SET_W | Set of the line to write back |
| wb_way | output | 2 | Way of the line to write back |
| wb_ack | input | 1 | Write-back acknowledge from the data path |

## Verification
The assertions assume the data path raises `wb_ack` only while `wb_req` is high, and that the entry and control registers are not written in the same cycle, since a control command uses the entry value held before that cycle. The bench drives every strobe for one cycle on the falling edge, pulses `wb_ack` only during an outstanding request, and writes the two registers in separate cycles. Write-through tests use only the H bit, so no Modified line is created in that mode.

// File: rtl/cache_tr_pkg.sv
package cache_tr_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_EXC = 2'b01,
    LS_SHR = 2'b10,
    LS_MOD = 2'b11
  } line_state_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_STATE = 2'b01,
    OP_LRU   = 2'b10,
    OP_FLUSH = 2'b11
  } tr_op_e;

  localparam int unsigned NUM_WAYS = 4;
  localparam int unsigned LRU_W    = 3;

  // In write-through compatibility only the H bit survives.
  function automatic logic [1:0] legal_state(input logic [1:0] req, input logic wb_mode);
    return wb_mode ? req : {req[1], 1'b0};
  endfunction

  function automatic logic [31:0] pack_status(input logic wb_mode, input logic [7:0] ways,
                                              input logic [1:0] way, input logic [2:0] lru);
    logic [31:0] r;
    r = '0;
    r[6:4] = lru;
    if (wb_mode) r[1:0] = ways[way*2 +: 2];
    else begin
      for (int i = 0; i < NUM_WAYS; i++) r[i] = ways[2*i+1];
    end
    return r;
  endfunction

endpackage

// File: rtl/cache_state_array.sv
module cache_state_array
  import cache_tr_pkg::*;
#(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned SET_W    = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [1:0]       wr_way,
  input  logic [1:0]       wr_val,
  input  logic [SET_W-1:0] rd_set,
  output logic [7:0]       rd_ways,
  output logic             any_valid
);
  localparam int unsigned ROW_W = 2 * NUM_WAYS;

  logic [ROW_W-1:0] mem [NUM_SETS];

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      for (int s = 0; s < NUM_SETS; s++) mem[s] <= '0;
    end else if (wr_en) begin
      mem[wr_set][wr_way*2 +: 2] <= wr_val;
    end
  end

  assign rd_ways = mem[rd_set];

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < NUM_SETS; s++) any_valid = any_valid | (|mem[s]);
  end

  assert_global_state_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> !any_valid);

  assert_no_write_with_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |-> !wr_en);

endmodule

// File: rtl/cache_lru_array.sv
module cache_lru_array
  import cache_tr_pkg::*;
#(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned SET_W    = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [LRU_W-1:0] wr_val,
  input  logic [SET_W-1:0] rd_set,
  output logic [LRU_W-1:0] rd_lru,
  output logic             any_set
);
  logic [LRU_W-1:0] mem [NUM_SETS];

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      for (int s = 0; s < NUM_SETS; s++) mem[s] <= '0;
    end else if (wr_en) begin
      mem[wr_set] <= wr_val;
    end
  end

  assign rd_lru = mem[rd_set];

  always_comb begin
    any_set = 1'b0;
    for (int s = 0; s < NUM_SETS; s++) any_set = any_set | (|mem[s]);
  end

  assert_global_lru_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> !any_set);

endmodule

// File: rtl/cache_flush_seq.sv
module cache_flush_seq
  import cache_tr_pkg::*;
#(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned SET_W    = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_mode,
  input  logic             ent_we,
  input  logic [SET_W+1:0] ent_wdata,
  input  logic             ctl_we,
  input  logic [13:0]      ctl_wdata,
  input  logic [7:0]       rd_ways,
  input  logic [LRU_W-1:0] rd_lru,
  output logic [SET_W-1:0] sel_set,
  output logic             clr_all,
  output logic             st_wr_en,
  output logic [SET_W-1:0] st_wr_set,
  output logic [1:0]       st_wr_way,
  output logic [1:0]       st_wr_val,
  output logic             lru_wr_en,
  output logic [LRU_W-1:0] lru_wr_val,
  output logic [31:0]      stat_rdata,
  output logic             busy,
  output logic             wb_req,
  output logic [SET_W-1:0] wb_set,
  output logic [1:0]       wb_way,
  input  logic             wb_ack
);
  logic [SET_W-1:0] set_q;
  logic [1:0]       way_q;
  logic             pend_q;
  logic [SET_W-1:0] pset_q;
  logic [1:0]       pway_q;
  logic [31:0]      stat_q;

  // Named decode events
  tr_op_e      op;
  logic        ctl_take, ent_take;
  logic        do_read, do_state, do_lru;
  logic        flush_all, flush_line, flush_line_mod, flush_line_clean;
  logic        ack_take;
  logic [1:0]  sel_state;
  logic        spare_nonzero;

  assign op              = tr_op_e'(ctl_wdata[1:0]);
  assign ctl_take        = ctl_we && !pend_q;
  assign ent_take        = ent_we && !pend_q;
  assign do_read         = ctl_take && (op == OP_READ);
  assign do_state        = ctl_take && (op == OP_STATE);
  assign do_lru          = ctl_take && (op == OP_LRU);
  assign flush_all       = ctl_take && (op == OP_FLUSH) && !ctl_wdata[13];
  assign flush_line      = ctl_take && (op == OP_FLUSH) &&  ctl_wdata[13];
  assign sel_state       = rd_ways[way_q*2 +: 2];
  assign flush_line_mod  = flush_line && (sel_state == LS_MOD);
  assign flush_line_clean= flush_line && (sel_state != LS_MOD);
  assign ack_take        = pend_q && wb_ack;
  assign spare_nonzero   = |ctl_wdata[12:2];

  assign sel_set = set_q;

  // Entry register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_q <= '0;
      way_q <= '0;
    end else if (ent_take) begin
      way_q <= ent_wdata[1:0];
      set_q <= ent_wdata[SET_W+1:2];
    end
  end

  // Write-back handshake
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pset_q <= '0;
      pway_q <= '0;
    end else if (flush_line_mod) begin
      pend_q <= 1'b1;
      pset_q <= set_q;
      pway_q <= way_q;
    end else if (ack_take) begin
      pend_q <= 1'b0;
    end
  end

  // Status register
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else if (do_read) stat_q <= pack_status(wb_mode, rd_ways, way_q, rd_lru);
  end

  // Array write port selection
  always_comb begin
    st_wr_en  = 1'b0;
    st_wr_set = set_q;
    st_wr_way = way_q;
    st_wr_val = LS_INV;
    if (ack_take) begin
      st_wr_en  = 1'b1;
      st_wr_set = pset_q;
      st_wr_way = pway_q;
    end else if (do_state) begin
      st_wr_en  = 1'b1;
      st_wr_val = legal_state(ctl_wdata[3:2], wb_mode);
    end else if (flush_line_clean) begin
      st_wr_en  = 1'b1;
    end
  end

  assign clr_all    = flush_all;
  assign lru_wr_en  = do_lru;
  assign lru_wr_val = ctl_wdata[6:4];

  assign stat_rdata = stat_q;
  assign busy       = pend_q;
  assign wb_req     = pend_q;
  assign wb_set     = pset_q;
  assign wb_way     = pway_q;

  assert_req_from_modified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_req) |-> $past(flush_line_mod));

  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_set) && $stable(wb_way)));

  assert_ack_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && wb_ack) |=> (!wb_req && !busy));

  assert_busy_blocks_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wb_ack) |-> (!st_wr_en && !lru_wr_en && !clr_all));

  assert_global_flush_no_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && spare_nonzero) |=> !wb_req);

endmodule

// File: rtl/cache_tr_flush.sv
module cache_tr_flush
  import cache_tr_pkg::*;
#(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned SET_W    = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_mode,
  input  logic             ent_we,
  input  logic [SET_W+1:0] ent_wdata,
  input  logic             ctl_we,
  input  logic [13:0]      ctl_wdata,
  output logic [31:0]      stat_rdata,
  output logic             busy,
  output logic             wb_req,
  output logic [SET_W-1:0] wb_set,
  output logic [1:0]       wb_way,
  input  logic             wb_ack
);
  logic [SET_W-1:0] sel_set;
  logic [7:0]       rd_ways;
  logic [LRU_W-1:0] rd_lru;
  logic             clr_all;
  logic             st_wr_en;
  logic [SET_W-1:0] st_wr_set;
  logic [1:0]       st_wr_way;
  logic [1:0]       st_wr_val;
  logic             lru_wr_en;
  logic [LRU_W-1:0] lru_wr_val;
  logic             any_valid;
  logic             any_lru;

  cache_flush_seq #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_seq (
    .clk, .rst_n, .wb_mode, .ent_we, .ent_wdata, .ctl_we, .ctl_wdata,
    .rd_ways, .rd_lru, .sel_set, .clr_all,
    .st_wr_en, .st_wr_set, .st_wr_way, .st_wr_val,
    .lru_wr_en, .lru_wr_val, .stat_rdata, .busy,
    .wb_req, .wb_set, .wb_way, .wb_ack
  );

  cache_state_array #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_state (
    .clk, .rst_n, .clr_all,
    .wr_en(st_wr_en), .wr_set(st_wr_set), .wr_way(st_wr_way), .wr_val(st_wr_val),
    .rd_set(sel_set), .rd_ways, .any_valid
  );

  cache_lru_array #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_lru (
    .clk, .rst_n, .clr_all,
    .wr_en(lru_wr_en), .wr_set(sel_set), .wr_val(lru_wr_val),
    .rd_set(sel_set), .rd_lru, .any_set(any_lru)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!any_valid && !any_lru && !busy));

endmodule

// File: tb/cache_tr_flush_bench.sv
module cache_tr_flush_bench;
  localparam int SET_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wb_mode = 1'b1;
  logic             ent_we = 1'b0;
  logic [SET_W+1:0] ent_wdata = '0;
  logic             ctl_we = 1'b0;
  logic [13:0]      ctl_wdata = '0;
  logic [31:0]      stat_rdata;
  logic             busy, wb_req;
  logic [SET_W-1:0] wb_set;
  logic [1:0]       wb_way;
  logic             wb_ack = 1'b0;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  cache_tr_flush #(.NUM_SETS(16), .SET_W(SET_W)) u_cache_tr_flush (
    .clk, .rst_n, .wb_mode, .ent_we, .ent_wdata, .ctl_we, .ctl_wdata,
    .stat_rdata, .busy, .wb_req, .wb_set, .wb_way, .wb_ack
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pick(input int s, input int w);  // R11 layout
    @(negedge clk);
    ent_we = 1'b1;
    ent_wdata = {4'(s), 2'(w)};
    @(negedge clk);
    ent_we = 1'b0;
  endtask

  task automatic ctl(input logic [13:0] d);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic rd(output logic [31:0] v);
    ctl(14'h0000);
    v = stat_rdata;
  endtask

  function automatic logic [13:0] put_state(input logic [1:0] s);
    return 14'({s, 2'b01});
  endfunction

  function automatic logic [13:0] put_lru(input logic [2:0] l);
    return 14'({l, 2'b00, 2'b10});
  endfunction

  function automatic logic [31:0] wb_view(input logic [2:0] l, input logic [1:0] s);
    return (32'(l) << 4) | 32'(s);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 wb_req", 32'(wb_req), 0);
    chk("R1 status", stat_rdata, 0);
    pick(9, 3);
    rd(v);
    chk("R1 line 9/3", v, 0);
  endtask

  task automatic t_state_rw();
    logic [31:0] v;
    pick(3, 2); ctl(put_state(2'b11));
    pick(3, 1); ctl(put_state(2'b01));
    pick(3, 0); ctl(put_state(2'b10));
    pick(3, 2); rd(v); chk("R2 modified", v, wb_view(0, 2'b11));
    pick(3, 1); rd(v); chk("R2 exclusive", v, wb_view(0, 2'b01));
    pick(3, 0); rd(v); chk("R2 shared", v, wb_view(0, 2'b10));
  endtask

  task automatic t_lru();
    logic [31:0] v;
    pick(3, 1); ctl(put_lru(3'b101));
    rd(v); chk("R4 lru with state", v, wb_view(3'b101, 2'b01));
    pick(4, 0); rd(v); chk("R4 other set lru", v, 0);
  endtask

  task automatic t_wt();
    logic [31:0] v;
    wb_mode = 1'b0;
    pick(7, 0); ctl(put_state(2'b11));
    pick(7, 2); ctl(put_state(2'b10));
    rd(v); chk("R3 H bits per way", v, 32'b0101);
    wb_mode = 1'b1;
    pick(7, 0); rd(v); chk("R3 L dropped", v, 32'b10);
  endtask

  task automatic t_line_clean();
    logic [31:0] v;
    pick(3, 1);
    ctl(14'h2003);
    chk("R6 no busy", 32'(busy), 0);
    chk("R6 no wb_req", 32'(wb_req), 0);
    rd(v); chk("R6 line invalid, lru kept", v, wb_view(3'b101, 2'b00));
    pick(3, 2); rd(v); chk("R6 neighbour kept", v, wb_view(3'b101, 2'b11));
  endtask

  task automatic t_line_mod();
    logic [31:0] v;
    pick(3, 2);
    ctl(14'h2003);
    chk("R7 busy", 32'(busy), 1);
    chk("R7 wb_req", 32'(wb_req), 1);
    chk("R7 wb_set", 32'(wb_set), 3);
    chk("R7 wb_way", 32'(wb_way), 2);
    pick(3, 0);                 // ignored while busy
    ctl(put_lru(3'b111));       // ignored while busy
    repeat (3) @(negedge clk);
    chk("R8 request held", 32'({wb_req, wb_set, wb_way}), 32'({1'b1, 4'd3, 2'd2}));
    wb_ack = 1'b1;
    @(negedge clk);
    wb_ack = 1'b0;
    chk("R8 wb_req dropped", 32'(wb_req), 0);
    chk("R8 busy dropped", 32'(busy), 0);
    rd(v); chk("R8 R9 line cleared, entry and lru kept", v, wb_view(3'b101, 2'b00));
  endtask

  task automatic t_spare_bits();
    logic [31:0] v;
    pick(5, 3); ctl(put_state(2'b10)); ctl(put_lru(3'b011));
    ctl(14'h2000 | 14'h1FFC | 14'h0003);
    chk("R10 no wb_req", 32'(wb_req), 0);
    rd(v); chk("R10 only line flushed", v, wb_view(3'b011, 2'b00));
  endtask

  task automatic t_global();
    logic [31:0] v;
    pick(5, 1); ctl(put_state(2'b11));
    pick(6, 0); ctl(put_state(2'b01)); ctl(put_lru(3'b110));
    ctl(14'h1FFF);
    chk("R5 busy low", 32'(busy), 0);
    chk("R5 wb_req low", 32'(wb_req), 0);
    rd(v); chk("R5 set 6", v, 0);
    pick(5, 1); rd(v); chk("R5 set 5 modified gone", v, 0);
    pick(3, 0); rd(v); chk("R5 set 3", v, 0);
    @(negedge clk);
    chk("R5 no later wb_req", 32'(wb_req), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_state_rw();
    t_lru();
    t_wt();
    t_line_clean();
    t_line_mod();
    t_spare_bits();
    t_global();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule